// File: doc/BRIEF.md
# EEPROM Command and Write Sequencer

This block sits between the byte-level side of an I2C target front end and a 512-byte non-volatile array, organised as two halves of 256 bytes. The front end reports START and STOP conditions, received bytes, the master's no-acknowledge and its requests for the next outgoing byte. The sequencer turns these events into device selection, word addressing, write buffering and reads that return data. It answers every received byte with an acknowledge decision made in the same cycle.

Write data is collected in an internal page buffer. The STOP that closes a write command starts a programming cycle of fixed length, counted in system clocks. During that cycle the buffered bytes are copied into the array and the block reports itself busy. Two pins gate each write when the STOP arrives. One is a write-control pin. The other is a protect pin, which takes effect only when bit 2 of the byte at address 1FFh is also set. A mode pin chooses between an aligned 8-byte page and an aligned 4-byte group.

The array port is a plain synchronous memory: address, write enable and write data, with read data that appears one cycle after the address.

Top module: `eep_seq`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 equal 1010 and bits 3:2 equal `ce[1:0]`. Bit 1 is the half-select address bit A8 and bit 0 is the read flag. After a select byte that does not match, no byte is acknowledged until the next START.
- R2: After a select byte with the read flag clear, the next byte sets the address counter to {A8, byte}. That byte and every later data byte are acknowledged.
- R3: With `mode_sel` low when the word address arrives, data bytes go to an aligned 8-byte page. The low three address bits wrap, and a later byte overwrites an earlier byte in the same slot. The counter ends at the slot that follows the last byte.
- R4: With `mode_sel` high when the word address arrives, the same rules apply to an aligned 4-byte group, and the low two address bits wrap.
- R5: A STOP that ends a write command holding at least one data byte raises `busy` for exactly PROG_CYCLES cycles, starting on the cycle after the STOP is sampled. A STOP that follows only a word address starts nothing.
- R6: While `busy` is high no byte is acknowledged and START is ignored. `mem_we` is asserted only while `busy` is high.
- R7: If `wr_ctl` is high when the STOP arrives, the data bytes are still acknowledged, but the array is unchanged and `busy` stays low.
- R8: If `prot_en` is high and bit 2 of the byte at 1FFh is set when the STOP arrives, the write is blocked in the same way as in R7. Either condition on its own does not block the write.
- R9: A random read is a write-select byte, a word address, a repeated START and a read-select byte. The read then starts at that word address, and the A8 bit of the read-select byte is ignored.
- R10: In a read, each `tx_req` loads `tx_byte` on the next cycle with the byte at the counter and then increments the counter. The counter wraps from 1FFh to 000h. At all other times `tx_byte` holds its value.
- R11: A current-address read (START and a read-select byte) returns the byte at the counter, continuing from where the last operation left it.
- R12: After `mst_nack` in a read, further `tx_req` pulses change neither `tx_byte` nor the counter until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce | input | 2 | Chip-enable value compared with select bits 3:2 |
| mode_sel | input | 1 | 0 = 8-byte page, 1 = 4-byte group |
| wr_ctl | input | 1 | High blocks writes |
| prot_en | input | 1 | Protect enable, qualified by bit 2 of byte 1FFh |
| ev_start | input | 1 | START (or repeated START) seen, one-cycle pulse |
| ev_stop | input | 1 | STOP seen, one-cycle pulse |
| rx_valid | input | 1 | A byte from the master is present |
| rx_byte | input | 8 | Byte received from the master |
| ack | output | 1 | Acknowledge decision for the byte on `rx_byte` |
| tx_req | input | 1 | Front end wants the next read byte |
| mst_nack | input | 1 | Master did not acknowledge the last read byte |
| tx_byte | output | 8 | Byte to shift out to the master |
| busy | output | 1 | Programming cycle or power-up load in progress |
| mem_addr | output | 9 | Array address |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one cycle after the address |

## Verification
The bench writes 10 bytes into an 8-byte page and 6 bytes into a 4-byte group. A design that fails to wrap would spill into the neighbouring page or group, and one that wraps the wrong field would lose the bytes that should overwrite earlier ones. It reads across 1FFh, so a counter that saturates, or that wraps only inside a 256-byte half, returns the wrong bytes. It exercises both protection paths: write control on its own, and the protect pin with and without the flag bit at 1FFh set. A sequencer that ignores either path corrupts the array, and one that blocks on the protect pin alone refuses a legal write. It also sends a select byte while programming is in progress, pulses `tx_req` after a no-acknowledge, and issues a STOP after a bare word address. Errors in these three cases show up as a wrong acknowledge, a counter that keeps moving, or a busy period that should never have started.

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int PROG_CYCLES = 40,
  parameter int PAGE_BYTES  = 8,
  parameter int GROUP_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ce,
  input  logic       mode_sel,
  input  logic       wr_ctl,
  input  logic       prot_en,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       ack,
  input  logic       tx_req,
  input  logic       mst_nack,
  output logic [7:0] tx_byte,
  output logic       busy,
  output logic [8:0] mem_addr,
  output logic       mem_we,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_SEL, S_WADR, S_WDAT, S_RD, S_RDEND, S_PROG} st_t;
  st_t st;

  logic [8:0]            ptr;
  logic                  blk, grp, prot;
  logic [7:0]            wbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] wval;
  logic [CW-1:0]         cnt;

  wire [8:0]    gmask   = grp ? 9'(GROUP_BYTES - 1) : 9'(PAGE_BYTES - 1);
  wire [8:0]    next_in = (ptr & ~gmask) | ((ptr + 9'd1) & gmask);
  wire [PW-1:0] widx    = ptr[PW-1:0] & gmask[PW-1:0];
  wire [PW-1:0] slot    = cnt[PW-1:0];
  wire          sel_ok  = rx_byte[7:4] == 4'b1010 && rx_byte[3:2] == ce;
  wire          blocked = wr_ctl || (prot_en && prot);

  assign busy      = st == S_INIT || st == S_PROG;
  assign ack       = rx_valid && ((st == S_SEL && sel_ok) || st == S_WADR || st == S_WDAT);
  assign mem_we    = st == S_PROG && cnt < CW'(PAGE_BYTES) && wval[slot];
  assign mem_wdata = wbuf[slot];
  assign mem_addr  = st == S_INIT ? 9'h1FF :
                     st == S_PROG ? ((ptr & ~gmask) | 9'(slot)) : ptr;

  always_ff @(posedge clk)
    if (st == S_WDAT && rx_valid && !ev_start && !ev_stop) wbuf[widx] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_INIT;
      ptr     <= '0;
      blk     <= 1'b0;
      grp     <= 1'b0;
      prot    <= 1'b0;
      wval    <= '0;
      cnt     <= '0;
      tx_byte <= '0;
    end else if (st == S_PROG) begin
      if (mem_we && mem_addr == 9'h1FF) prot <= mem_wdata[2];
      if (cnt == CW'(PROG_CYCLES - 1)) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else cnt <= cnt + 1'b1;
    end else if (st == S_INIT) begin
      prot <= mem_rdata[2];
      st   <= S_IDLE;
    end else if (ev_start) begin
      st <= S_SEL;
    end else if (ev_stop) begin
      st <= (st == S_WDAT && wval != '0 && !blocked) ? S_PROG : S_IDLE;
    end else begin
      case (st)
        S_SEL: if (rx_valid) begin
          if (!sel_ok) st <= S_IDLE;
          else if (rx_byte[0]) st <= S_RD;
          else begin
            blk <= rx_byte[1];
            st  <= S_WADR;
          end
        end
        S_WADR: if (rx_valid) begin
          ptr  <= {blk, rx_byte};
          grp  <= mode_sel;
          wval <= '0;
          st   <= S_WDAT;
        end
        S_WDAT: if (rx_valid) begin
          wval[widx] <= 1'b1;
          ptr        <= next_in;
        end
        S_RD: begin
          if (mst_nack) st <= S_RDEND;
          else if (tx_req) begin
            tx_byte <= mem_rdata;
            ptr     <= ptr + 9'd1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module eep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_we,
  input logic       ack,
  input logic       rx_valid,
  input logic       ev_stop,
  input logic       wr_ctl,
  input logic       tx_req,
  input logic [7:0] tx_byte,
  input logic [8:0] mem_addr
);
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy); // R6
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && rx_valid) |-> !ack); // R6
  AST_WC_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (ev_stop && wr_ctl && !busy) |=> !busy); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tx_req |=> $stable(tx_byte)); // R10
  AST_PAGE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[8:3] == $past(mem_addr[8:3])); // R3
endmodule

bind eep_seq eep_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .ack(ack),
  .rx_valid(rx_valid), .ev_stop(ev_stop), .wr_ctl(wr_ctl), .tx_req(tx_req),
  .tx_byte(tx_byte), .mem_addr(mem_addr)
);

// File: tb/sim_eep_seq.sv
`timescale 1ns/1ps
module sim_eep_seq;
  localparam int P = 40;
  localparam logic [1:0] CEV = 2'b10;

  logic clk = 0, rst_n = 0;
  logic [1:0] ce = CEV;
  logic mode_sel = 0, wr_ctl = 0, prot_en = 0;
  logic ev_start = 0, ev_stop = 0, rx_valid = 0, tx_req = 0, mst_nack = 0;
  logic [7:0] rx_byte = 0;
  logic ack, busy, mem_we;
  logic [7:0] tx_byte, mem_wdata, mem_rdata;
  logic [8:0] mem_addr;

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  logic [7:0] wdat [16];
  int nchk = 0, nerr = 0, left = 0, pend = 0, cur = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  eep_seq #(.PROG_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .mode_sel(mode_sel), .wr_ctl(wr_ctl),
    .prot_en(prot_en), .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ack(ack), .tx_req(tx_req), .mst_nack(mst_nack),
    .tx_byte(tx_byte), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    if (pend != 0) begin left = P; pend = 0; end
    chk(busy == (left > 0), "R5", busy, left > 0);
    chk(!(mem_we && !busy), "R6", mem_we, 0);
    if (left > 0) left--;
  end

  task automatic pulse_start();
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
  endtask

  task automatic pulse_stop(bit launch);
    @(negedge clk) ev_stop = 1;
    @(posedge clk) #1 if (launch) pend = 1;
    @(negedge clk) ev_stop = 0;
  endtask

  task automatic send(logic [7:0] b, bit exp_ack, string req);
    @(negedge clk) rx_valid = 1; rx_byte = b;
    #1 chk(ack == exp_ack, req, ack, exp_ack);
    @(negedge clk) rx_valid = 0;
  endtask

  task automatic rdbyte(logic [7:0] exp, string req);
    @(negedge clk) tx_req = 1;
    @(negedge clk) tx_req = 0;
    #1 chk(tx_byte == exp, req, tx_byte, exp);
    @(negedge clk);
  endtask

  task automatic do_write(int a, int n, bit m, bit wait_done, string req);
    int g, base;
    bit launch;
    mode_sel = m;
    g = m ? 4 : 8;
    base = a & ~(g - 1);
    pulse_start();
    send({4'hA, CEV, 1'(a >> 8), 1'b0}, 1, "R1");
    send(8'(a), 1, "R2");
    for (int k = 0; k < n; k++) send(wdat[k], 1, req);
    launch = n > 0 && !wr_ctl && !(prot_en && exp_mem[511][2]);
    if (launch)
      for (int k = 0; k < n; k++) exp_mem[base | ((a + k) & (g - 1))] = wdat[k];
    cur = base | ((a + n) & (g - 1));
    pulse_stop(launch);
    if (wait_done) repeat (P + 3) @(negedge clk);
  endtask

  task automatic rd_rand(int a, int n, string req);
    pulse_start();
    send({4'hA, CEV, 1'(a >> 8), 1'b0}, 1, "R1");
    send(8'(a), 1, "R2");
    pulse_start();
    send({4'hA, CEV, ~1'(a >> 8), 1'b1}, 1, "R9");
    for (int k = 0; k < n; k++) rdbyte(exp_mem[(a + k) % 512], req);
    cur = (a + n) % 512;
    @(negedge clk) mst_nack = 1;
    @(negedge clk) mst_nack = 0;
  endtask

  task automatic rd_cur(int n, string req);
    pulse_start();
    send({4'hA, CEV, 2'b01}, 1, "R1");
    for (int k = 0; k < n; k++) rdbyte(exp_mem[(cur + k) % 512], req);
    cur = (cur + n) % 512;
    @(negedge clk) mst_nack = 1;
    @(negedge clk) mst_nack = 0;
    pulse_stop(0);
  endtask

  task automatic fill(int seed, int n);
    for (int k = 0; k < n; k++) wdat[k] = 8'(seed + 7 * k);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = 0; exp_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 0, "R6 reset", busy, 0);
    chk(tx_byte == 0, "R10 reset", tx_byte, 0);
    chk(mem_we == 0, "R6 reset", mem_we, 0);
    cmp_on = 1;

    fill(8'hA5, 1);
    do_write(9'h010, 1, 0, 1, "R2");
    rd_rand(9'h010, 1, "R2");
    pulse_stop(0);

    fill(8'h31, 8);
    do_write(9'h120, 8, 0, 1, "R3");
    rd_rand(9'h120, 8, "R3");
    pulse_stop(0);
    rd_cur(2, "R11");

    fill(8'h52, 10);
    do_write(9'h035, 10, 0, 1, "R3");
    rd_rand(9'h030, 8, "R3");
    pulse_stop(0);

    fill(8'hC0, 6);
    do_write(9'h042, 6, 1, 1, "R4");
    rd_rand(9'h040, 8, "R4");
    pulse_stop(0);
    mode_sel = 0;

    pulse_start();
    send({4'hA, 2'b01, 2'b00}, 0, "R1");
    send(8'h55, 0, "R1");
    pulse_stop(0);

    do_write(9'h050, 0, 0, 1, "R5");

    fill(8'h11, 2);
    do_write(9'h0A0, 2, 0, 0, "R5");
    pulse_start();
    send({4'hA, CEV, 2'b00}, 0, "R6");
    repeat (P + 3) @(negedge clk);
    rd_rand(9'h0A0, 2, "R6");
    pulse_stop(0);

    wr_ctl = 1;
    fill(8'h77, 3);
    do_write(9'h060, 3, 0, 1, "R7");
    wr_ctl = 0;
    rd_rand(9'h060, 3, "R7");
    pulse_stop(0);

    prot_en = 1;
    fill(8'h21, 2);
    do_write(9'h070, 2, 0, 1, "R8");
    prot_en = 0;
    wdat[0] = 8'h04;
    do_write(9'h1FF, 1, 0, 1, "R8");
    prot_en = 1;
    fill(8'h90, 2);
    do_write(9'h078, 2, 0, 1, "R8");
    rd_rand(9'h078, 2, "R8");
    pulse_stop(0);
    prot_en = 0;
    fill(8'h95, 2);
    do_write(9'h078, 2, 0, 1, "R8");
    rd_rand(9'h070, 10, "R8");
    pulse_stop(0);

    rd_rand(9'h1FE, 4, "R10");
    pulse_stop(0);

    fill(8'h40, 4);
    do_write(9'h080, 4, 0, 1, "R12");
    rd_rand(9'h080, 2, "R12");
    @(negedge clk) tx_req = 1;
    @(negedge clk) tx_req = 0;
    #1 chk(tx_byte == exp_mem[9'h081], "R12", tx_byte, exp_mem[9'h081]);
    @(negedge clk);
    pulse_stop(0);
    rd_cur(1, "R12");

    repeat (4) @(negedge clk);
    for (int i = 0; i < 512; i++) chk(mem[i] == exp_mem[i], "R3", mem[i], exp_mem[i]);
    finish_up();
  end
endmodule